// File: doc/BRIEF.md
# UART Interrupt and FIFO Control

This block is the register-side interrupt and FIFO control of a 16550-compatible serial port. It stores the four interrupt enable bits. It decodes writes to the write-only FIFO control location, which shares its offset with the interrupt identification register. It also merges five raw event inputs with the enables: received data ready, receive character timeout, transmit holding empty, receive line error and modem status change.

From the enabled events the block picks the highest-priority pending source. It reports that source as a four-bit identification code and drives one registered interrupt line. FIFO control writes become one-cycle clear strobes for the receive and transmit FIFOs. The receive trigger-level field is exported as a byte count for the receive FIFO threshold comparator. The FIFOs, the shifters, the baud generator and the line and modem status registers sit outside the block and feed it through the event inputs.

Top module: `uart_irq_ctl`

## Requirements
- R1: The enable register is at offset 1 and is written only when `dlab` is 0. Bits 3:0 are read back, bits 7:4 read as 0, and all bits reset to 0. A write at offset 1 with `dlab` = 1 leaves the register unchanged.
- R2: A read at offset 2 returns the identification byte: bits 3:0 hold the code, bits 5:4 are 0, and bits 7:6 both equal `fifo_mode`. The FIFO control contents cannot be read back.
- R3: When more than one enabled source is pending, the code reports the highest one. The order from highest to lowest is: line error 0110, received data 0100, character timeout 1100, transmit holding empty 0010, modem change 0000.
- R4: A source counts only when its enable is set. Enable bit 0 covers received data and timeout, bit 1 covers transmit holding empty, bit 2 covers line error and bit 3 covers modem change. With no enabled source pending, the code is 0001 and `irq` is low.
- R5: The character timeout source counts only while `fifo_mode` is 1.
- R6: `irq` is registered. At each clock it takes the value "some enabled source pending" from the cycle before.
- R7: A write at offset 2 with bit 1 set drives `rx_fifo_clr` high for exactly one cycle. With bit 2 set, it does the same for `tx_fifo_clr`. A write with these bits at 0 produces no strobe.
- R8: FIFO control bits 7:6 select the receive trigger. For the default depth of 16, code 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14 on `rx_trig_bytes`; the field resets to 00. Bit 3 is accepted and changes no output.
- R9: The transmit-holding-empty pending flag sets on a rising edge of `ev_thr_empty`. It also sets when enable bit 1 is written from 0 to 1 while `ev_thr_empty` is high. It clears on an identification read that reports code 0010, or on a write at offset 0 with `dlab` = 0.
- R10: An identification read that reports a higher-priority source leaves the transmit-holding-empty flag pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (enable or identification byte, else 0) |
| dlab | input | 1 | Divisor latch access bit from the line control register |
| fifo_mode | input | 1 | FIFOs enabled |
| ev_rx_avail | input | 1 | Received data available level |
| ev_rx_timeout | input | 1 | Receive character timeout level |
| ev_thr_empty | input | 1 | Transmit holding register or FIFO empty level |
| ev_line_err | input | 1 | Receive line error (overrun, parity, framing, break) pending |
| ev_modem_chg | input | 1 | Modem status change pending |
| irq | output | 1 | Serial port interrupt |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| rx_trig_bytes | output | TRIG_W | Receive trigger level in bytes |

## Verification
Read data and the identification code follow register state and event inputs with no clock, so the bench samples `bus_rdata` 1 ns after it drives a read, before the capturing edge. Register writes, the clear strobes, the trigger count and the transmit-empty flag take effect on the first rising edge after the inputs are driven. The bench drives them at a falling edge and checks at the next falling edge, then checks one cycle later that each strobe is low again. `irq` lags the pending state by one more register, so the bench checks that it is still low 1 ns after a change and high at the next falling edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   // Source indices, highest priority first
   localparam int NUM_SRC     = 5;
   localparam int SRC_LINE    = 0;
   localparam int SRC_RXDATA  = 1;
   localparam int SRC_TIMEOUT = 2;
   localparam int SRC_THRE    = 3;
   localparam int SRC_MODEM   = 4;

   // Identification codes
   localparam logic [3:0] IID_NONE    = 4'b0001;
   localparam logic [3:0] IID_LINE    = 4'b0110;
   localparam logic [3:0] IID_RXDATA  = 4'b0100;
   localparam logic [3:0] IID_TIMEOUT = 4'b1100;
   localparam logic [3:0] IID_THRE    = 4'b0010;
   localparam logic [3:0] IID_MODEM   = 4'b0000;

   // Register offsets
   localparam int OFS_DATA = 0;
   localparam int OFS_IER  = 1;
   localparam int OFS_IIR  = 2;

   typedef struct packed {
      logic wr_thr;
      logic wr_ier;
      logic wr_fcr;
      logic rd_ier;
      logic rd_iir;
   } bus_strb_t;

   function automatic logic [3:0] src_iid(input int idx);
      case (idx)
         SRC_LINE:    return IID_LINE;
         SRC_RXDATA:  return IID_RXDATA;
         SRC_TIMEOUT: return IID_TIMEOUT;
         SRC_THRE:    return IID_THRE;
         default:     return IID_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              dlab,
   output bus_strb_t         strb
);

   logic hit_data, hit_ier, hit_iir;

   assign hit_data = bus_sel && (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_ier  = bus_sel && (bus_addr == ADDR_W'(OFS_IER));
   assign hit_iir  = bus_sel && (bus_addr == ADDR_W'(OFS_IIR));

   always_comb begin
      strb.wr_thr = hit_data && bus_wr && !dlab;
      strb.wr_ier = hit_ier  && bus_wr && !dlab;
      strb.rd_ier = hit_ier  && bus_rd && !dlab;
      strb.wr_fcr = hit_iir  && bus_wr;
      strb.rd_iir = hit_iir  && bus_rd;
   end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TRIG_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_strb_t         strb,
   input  logic [3:0]        ier_wdata,
   input  logic [1:0]        trig_wdata,
   input  logic              rx_clr_req,
   input  logic              tx_clr_req,
   output logic [3:0]        ier_q,
   output logic              thre_en_rise,
   output logic              rx_fifo_clr,
   output logic              tx_fifo_clr,
   output logic [TRIG_W-1:0] rx_trig_bytes
);

   localparam int LVL_A = 1;
   localparam int LVL_B = FIFO_DEPTH / 4;
   localparam int LVL_C = FIFO_DEPTH / 2;
   localparam int LVL_D = FIFO_DEPTH - 2;

   if ((1 << TRIG_W) <= FIFO_DEPTH) begin : g_bad_trig_w
      $error("TRIG_W too narrow for FIFO_DEPTH");
   end

   logic [1:0] trig_sel_q;

   assign thre_en_rise = strb.wr_ier && ier_wdata[1] && !ier_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q       <= '0;
         trig_sel_q  <= '0;
         rx_fifo_clr <= 1'b0;
         tx_fifo_clr <= 1'b0;
      end else begin
         if (strb.wr_ier) ier_q <= ier_wdata;
         if (strb.wr_fcr) trig_sel_q <= trig_wdata;
         rx_fifo_clr <= strb.wr_fcr && rx_clr_req;
         tx_fifo_clr <= strb.wr_fcr && tx_clr_req;
      end
   end

   always_comb begin
      case (trig_sel_q)
         2'b00:   rx_trig_bytes = TRIG_W'(LVL_A);
         2'b01:   rx_trig_bytes = TRIG_W'(LVL_B);
         2'b10:   rx_trig_bytes = TRIG_W'(LVL_C);
         default: rx_trig_bytes = TRIG_W'(LVL_D);
      endcase
   end

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_thr_empty,
   input  logic thr_write,
   input  logic en_rise,
   input  logic iir_read,
   input  logic reported,
   output logic pend
);

   logic empty_d_q;
   logic pend_nxt;

   always_comb begin
      pend_nxt = pend;
      if (thr_write || (iir_read && reported)) pend_nxt = 1'b0;
      if ((ev_thr_empty && !empty_d_q) || (en_rise && ev_thr_empty)) pend_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_d_q <= 1'b0;
         pend      <= 1'b0;
      end else begin
         empty_d_q <= ev_thr_empty;
         pend      <= pend_nxt;
      end
   end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   input  logic [N-1:0] en,
   output logic [3:0]   iid_code,
   output logic         irq
);

   if (N != NUM_SRC) begin : g_bad_n
      $error("source count must match the code table");
   end

   logic [N-1:0] act;
   logic [N-1:0] win;
   logic [N:0]   seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_src
      assign act[i]    = raw[i] & en[i];
      assign win[i]    = act[i] & ~seen[i];
      assign seen[i+1] = seen[i] | act[i];
   end

   always_comb begin
      iid_code = seen[N] ? 4'b0000 : IID_NONE;
      for (int i = 0; i < N; i++) begin
         if (win[i]) iid_code = iid_code | src_iid(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= seen[N];
   end

endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int FIFO_DEPTH = 16,
   parameter int TRIG_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              dlab,
   input  logic              fifo_mode,
   input  logic              ev_rx_avail,
   input  logic              ev_rx_timeout,
   input  logic              ev_thr_empty,
   input  logic              ev_line_err,
   input  logic              ev_modem_chg,
   output logic              irq,
   output logic              rx_fifo_clr,
   output logic              tx_fifo_clr,
   output logic [TRIG_W-1:0] rx_trig_bytes
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover offsets 0 to 2");
   end
   if (FIFO_DEPTH < 8 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 8");
   end

   bus_strb_t          strb;
   logic [3:0]         ier_q;
   logic               thre_en_rise;
   logic               thre_pend;
   logic [3:0]         iid_code;
   logic [NUM_SRC-1:0] src_raw;
   logic [NUM_SRC-1:0] src_en;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata[5:4];

   uart_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .dlab     (dlab),
      .strb     (strb)
   );

   uart_irq_regs #(.FIFO_DEPTH(FIFO_DEPTH), .TRIG_W(TRIG_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .strb          (strb),
      .ier_wdata     (bus_wdata[3:0]),
      .trig_wdata    (bus_wdata[7:6]),
      .rx_clr_req    (bus_wdata[1]),
      .tx_clr_req    (bus_wdata[2]),
      .ier_q         (ier_q),
      .thre_en_rise  (thre_en_rise),
      .rx_fifo_clr   (rx_fifo_clr),
      .tx_fifo_clr   (tx_fifo_clr),
      .rx_trig_bytes (rx_trig_bytes)
   );

   uart_irq_thre u_thre (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_thr_empty (ev_thr_empty),
      .thr_write    (strb.wr_thr),
      .en_rise      (thre_en_rise),
      .iir_read     (strb.rd_iir),
      .reported     (iid_code == IID_THRE),
      .pend         (thre_pend)
   );

   always_comb begin
      src_raw              = '0;
      src_raw[SRC_LINE]    = ev_line_err;
      src_raw[SRC_RXDATA]  = ev_rx_avail;
      src_raw[SRC_TIMEOUT] = ev_rx_timeout & fifo_mode;
      src_raw[SRC_THRE]    = thre_pend;
      src_raw[SRC_MODEM]   = ev_modem_chg;
      src_en               = '0;
      src_en[SRC_LINE]     = ier_q[2];
      src_en[SRC_RXDATA]   = ier_q[0];
      src_en[SRC_TIMEOUT]  = ier_q[0];
      src_en[SRC_THRE]     = ier_q[1];
      src_en[SRC_MODEM]    = ier_q[3];
   end

   uart_irq_prio #(.N(NUM_SRC)) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (src_raw),
      .en       (src_en),
      .iid_code (iid_code),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = 8'h00;
      if (strb.rd_ier)      bus_rdata = {4'b0000, ier_q};
      else if (strb.rd_iir) bus_rdata = {{2{fifo_mode}}, 2'b00, iid_code};
   end

endmodule

// File: rtl/uart_irq_ctl_chk.sv
module uart_irq_ctl_chk
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        clr_bits,
   input logic [7:0]        bus_rdata,
   input logic              dlab,
   input logic              irq,
   input logic              rx_fifo_clr,
   input logic              tx_fifo_clr,
   input logic [3:0]        ier_q,
   input logic [3:0]        iid_code
);

   logic ier_rd, iir_rd, fcr_wr;
   assign ier_rd = bus_sel && bus_rd && (bus_addr == ADDR_W'(OFS_IER)) && !dlab;
   assign iir_rd = bus_sel && bus_rd && (bus_addr == ADDR_W'(OFS_IIR));
   assign fcr_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_IIR));

   AST_IER_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ier_rd |-> (bus_rdata[7:4] == 4'h0)); // R1
   AST_IIR_READ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      iir_rd |-> (bus_rdata[5:4] == 2'b00 && bus_rdata[3:0] == iid_code)); // R2
   AST_MASKED_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q == 4'h0) |-> (iid_code == IID_NONE)); // R4
   AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ier_q) == 4'h0) |-> !irq); // R4
   AST_IRQ_LAGS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(!iid_code[0])); // R6
   AST_RXCLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_clr |-> $past(fcr_wr && clr_bits[0])); // R7
   AST_TXCLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_clr |-> $past(fcr_wr && clr_bits[1])); // R7

endmodule

bind uart_irq_ctl uart_irq_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr),
   .clr_bits    (bus_wdata[2:1]),
   .bus_rdata   (bus_rdata),
   .dlab        (dlab),
   .irq         (irq),
   .rx_fifo_clr (rx_fifo_clr),
   .tx_fifo_clr (tx_fifo_clr),
   .ier_q       (ier_q),
   .iid_code    (iid_code)
);

// File: tb/uart_irq_ctl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       dlab = 1'b0, fifo_mode = 1'b1;
   logic       ev_rx_avail = 1'b0, ev_rx_timeout = 1'b0, ev_thr_empty = 1'b0;
   logic       ev_line_err = 1'b0, ev_modem_chg = 1'b0;
   logic       irq, rx_fifo_clr, tx_fifo_clr;
   logic [4:0] rx_trig_bytes;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   uart_irq_ctl u_uart_irq_ctl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dlab(dlab),
      .fifo_mode(fifo_mode), .ev_rx_avail(ev_rx_avail), .ev_rx_timeout(ev_rx_timeout),
      .ev_thr_empty(ev_thr_empty), .ev_line_err(ev_line_err), .ev_modem_chg(ev_modem_chg),
      .irq(irq), .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
      .rx_trig_bytes(rx_trig_bytes)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic dl);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; dlab = dl;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; dlab = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic dl, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a; dlab = dl;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0; dlab = 1'b0;
   endtask

   task automatic quiet();
      ev_rx_avail = 0; ev_rx_timeout = 0; ev_line_err = 0; ev_modem_chg = 0;
      wr(3'd1, 8'h00, 1'b0);
      wr(3'd0, 8'h00, 1'b0);   // THR write drops any pending empty flag
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R6 irq after reset", irq, 0);
      chk("R7 no rx strobe after reset", rx_fifo_clr, 0);
      chk("R7 no tx strobe after reset", tx_fifo_clr, 0);
      chk("R8 trigger after reset", rx_trig_bytes, 1);
      rd(3'd1, 1'b0, d); chk("R1 enable reset value", d, 8'h00);
      rd(3'd2, 1'b0, d); chk("R2 ident at reset", d, 8'hC1);
   endtask

   task automatic t_ier();
      logic [7:0] d;
      wr(3'd1, 8'hFF, 1'b0);
      rd(3'd1, 1'b0, d); chk("R1 upper bits read zero", d, 8'h0F);
      wr(3'd1, 8'h00, 1'b1);
      rd(3'd1, 1'b0, d); chk("R1 dlab=1 write ignored", d, 8'h0F);
      wr(3'd1, 8'h05, 1'b0);
      rd(3'd1, 1'b0, d); chk("R1 readback", d, 8'h05);
      quiet();
   endtask

   task automatic t_mask();
      logic [7:0] d;
      ev_line_err = 1; ev_rx_avail = 1; ev_rx_timeout = 1; ev_modem_chg = 1;
      @(negedge clk); ev_thr_empty = 1;
      @(negedge clk); @(negedge clk);
      rd(3'd2, 1'b0, d); chk("R4 all masked code", d, 8'hC1);
      chk("R4 all masked irq", irq, 0);
      wr(3'd1, 8'h04, 1'b0); rd(3'd2, 1'b0, d); chk("R4 only line enabled", d, 8'hC6);
      wr(3'd1, 8'h01, 1'b0); rd(3'd2, 1'b0, d); chk("R4 only rx enabled", d, 8'hC4);
      wr(3'd1, 8'h08, 1'b0); rd(3'd2, 1'b0, d); chk("R4 only modem enabled", d, 8'hC0);
      chk("R4 modem enabled irq", irq, 1);
      wr(3'd1, 8'h02, 1'b0); rd(3'd2, 1'b0, d); chk("R4 only thre enabled", d, 8'hC2);
      ev_thr_empty = 0;
      quiet();
   endtask

   task automatic t_prio();
      logic [7:0] d;
      wr(3'd1, 8'h0F, 1'b0);
      ev_line_err = 1; ev_rx_avail = 1; ev_rx_timeout = 1; ev_modem_chg = 1; ev_thr_empty = 1;
      @(negedge clk); @(negedge clk);
      rd(3'd2, 1'b0, d); chk("R3 line highest", d, 8'hC6);
      chk("R6 irq with all pending", irq, 1);
      ev_line_err = 0;
      rd(3'd2, 1'b0, d); chk("R3 rx over timeout", d, 8'hC4);
      ev_rx_avail = 0;
      rd(3'd2, 1'b0, d); chk("R3 timeout over thre", d, 8'hCC);
      ev_rx_timeout = 0;
      rd(3'd2, 1'b0, d); chk("R3 thre over modem", d, 8'hC2);
      rd(3'd2, 1'b0, d); chk("R9 read cleared thre, modem left", d, 8'hC0);
      ev_modem_chg = 0;
      rd(3'd2, 1'b0, d); chk("R3 none left", d, 8'hC1);
      @(negedge clk);
      chk("R6 irq drops", irq, 0);
      ev_thr_empty = 0;
      quiet();
   endtask

   task automatic t_timeout();
      logic [7:0] d;
      wr(3'd1, 8'h01, 1'b0);
      fifo_mode = 0; ev_rx_timeout = 1;
      rd(3'd2, 1'b0, d); chk("R5 timeout ignored, R2 bits7:6 zero", d, 8'h01);
      @(negedge clk); chk("R5 no irq without fifo mode", irq, 0);
      fifo_mode = 1;
      rd(3'd2, 1'b0, d); chk("R5 timeout in fifo mode", d, 8'hCC);
      quiet();
   endtask

   task automatic t_irq_lat();
      wr(3'd1, 8'h08, 1'b0);
      @(negedge clk); ev_modem_chg = 1;
      #1 chk("R6 irq not yet", irq, 0);
      @(negedge clk); chk("R6 irq one edge later", irq, 1);
      ev_modem_chg = 0;
      #1 chk("R6 irq held until edge", irq, 1);
      @(negedge clk); chk("R6 irq falls one edge later", irq, 0);
      quiet();
   endtask

   task automatic t_fcr();
      logic [7:0] d;
      wr(3'd2, 8'h02, 1'b0);
      chk("R7 rx strobe", {rx_fifo_clr, tx_fifo_clr}, 2'b10);
      @(negedge clk); chk("R7 rx strobe one cycle", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
      wr(3'd2, 8'h04, 1'b0);
      chk("R7 tx strobe", {rx_fifo_clr, tx_fifo_clr}, 2'b01);
      @(negedge clk); chk("R7 tx strobe one cycle", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
      wr(3'd2, 8'h06, 1'b0);
      chk("R7 both strobes", {rx_fifo_clr, tx_fifo_clr}, 2'b11);
      wr(3'd2, 8'h00, 1'b0);
      chk("R7 no strobe on zero", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
      wr(3'd2, 8'h40, 1'b0); chk("R8 trigger 01", rx_trig_bytes, 4);
      wr(3'd2, 8'h80, 1'b0); chk("R8 trigger 10", rx_trig_bytes, 8);
      wr(3'd2, 8'hC8, 1'b0); chk("R8 trigger 11 with bit3", rx_trig_bytes, 14);
      chk("R8 bit3 gives no strobe", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
      rd(3'd2, 1'b0, d); chk("R8 bit3 leaves ident", d, 8'hC1);
      rd(3'd1, 1'b0, d); chk("R2 fcr not readable at enable", d, 8'h00);
      wr(3'd2, 8'h00, 1'b0); chk("R8 trigger 00", rx_trig_bytes, 1);
   endtask

   task automatic t_thre();
      logic [7:0] d;
      wr(3'd1, 8'h02, 1'b0);
      @(negedge clk); ev_thr_empty = 1;
      @(negedge clk); @(negedge clk);
      chk("R9 edge raises irq", irq, 1);
      rd(3'd2, 1'b0, d); chk("R9 edge sets thre", d, 8'hC2);
      rd(3'd2, 1'b0, d); chk("R9 ident read clears thre", d, 8'hC1);
      ev_thr_empty = 0; @(negedge clk); ev_thr_empty = 1; @(negedge clk);
      wr(3'd0, 8'h55, 1'b0);
      rd(3'd2, 1'b0, d); chk("R9 THR write clears thre", d, 8'hC1);
      wr(3'd1, 8'h00, 1'b0);
      wr(3'd1, 8'h02, 1'b0);
      rd(3'd2, 1'b0, d); chk("R9 enable rise rearms thre", d, 8'hC2);
      wr(3'd1, 8'h06, 1'b0);
      ev_thr_empty = 0; @(negedge clk); ev_thr_empty = 1; @(negedge clk);
      ev_line_err = 1;
      rd(3'd2, 1'b0, d); chk("R10 line reported", d, 8'hC6);
      ev_line_err = 0;
      rd(3'd2, 1'b0, d); chk("R10 thre still pending", d, 8'hC2);
      rd(3'd2, 1'b0, d); chk("R9 cleared after report", d, 8'hC1);
      ev_thr_empty = 0;
      quiet();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ier();
      t_mask();
      t_prio();
      t_timeout();
      t_irq_lat();
      t_fcr();
      t_thre();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule